// File: doc/BRIEF.md
# Memory deskew training sequencer

This block is the controller-side sequencer that calibrates a quad-data-rate SRAM interface after reset. Once started, it writes the option control register with the training-enable bit set. It then runs three calibration phases in a fixed order:

1. Address/control loopback, with the three loopback groups checked one after another.
2. Read data, using an all-ones write followed by a read-back that must toggle.
3. Write data, using a normal write of a fixed pattern followed by a read-back that must match.

Between the read phase and the write phase it makes a second configuration pass that clears the training-enable bit.

Each phase samples the lane data returned by the capture logic over a fixed window and compares it with the expected pattern for that phase. The per-lane mismatches are collected into a mask. A non-empty mask raises an adjust request that carries the mask. When the delay tuner answers with an aligned pulse, the step is repeated. A programmable per-phase cycle budget ends a phase that cannot converge: the sequencer records which phase failed and finishes with a fail status. The sequencer ends with a one-cycle done pulse and a sticky pass or fail status.

Top module: `dsk_train_seq`

## Requirements
- R1: A start accepted in the idle or terminal state gives exactly one cycle with cfgMode and regWrEn high and regWrData = 0x80 (bit 7 is the training enable). During that cycle loopSel is 3 and no command is issued.
- R2: The loopback phase drives loopSel 0, then 1, then 2. Each group is sampled for WIN cycles, with every lane expected high. While loopSel is not 3 no write or read command is issued. loopSel returns to 3 when the phase ends.
- R3: During a sampling window, any sample that differs from the phase's expected data raises adjustReq. adjustLanes then carries the mismatching lanes (bit n set for lane n). adjustReq stays high until aligned is seen, and then the same step is repeated.
- R4: The read phase issues one write with all-ones data and then one read. The valid samples of the window must be all ones, all zeros, all ones, and so on, starting from all ones. A retry after adjust repeats both the write and the read.
- R5: After the read phase passes, one cycle with cfgMode and regWrEn high and regWrData = 0x00 comes before any write-phase command.
- R6: The write phase issues a write with wrData = WR_PATTERN (default 0x0A5A) followed by a read. Every valid sample must equal WR_PATTERN. A retry repeats the write and the read.
- R7: Each phase has a cycle counter that is cleared when the phase is entered. When the counter reaches timeoutCycles, the phase's bit in phaseErr is set and the sequencer fails. The bits are: bit 0 for loopback, bit 1 for read, bit 2 for write. For a loopback phase that never aligns, done appears timeoutCycles+1 cycles after loopSel first shows 0.
- R8: done is high for exactly one cycle, together with exactly one of trainPass or trainFail. The status holds in the terminal state with busy low. After reset, done, busy, the status outputs and phaseErr are 0, and loopSel is 3.
- R9: A start while busy is ignored: the run continues and no new configuration write with bit 7 set occurs.
- R10: A start accepted in the terminal state clears trainPass, trainFail and phaseErr, and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a training run |
| timeoutCycles | input | TW | Cycle budget for each phase |
| capValid | input | 1 | The captured lane sample is valid this cycle |
| capData | input | LANES | Captured lane sample |
| aligned | input | 1 | Delay tuner has finished the requested adjustment |
| cfgMode | output | 1 | Configuration-mode strobe |
| regWrEn | output | 1 | Option register write strobe |
| regWrData | output | 8 | Option register value, bit 7 is the training enable |
| loopSel | output | 2 | Loopback group select, 3 means no loopback |
| cmdWrite | output | 1 | Write command |
| cmdRead | output | 1 | Read command |
| wrData | output | LANES | Data sent with the write command |
| adjustReq | output | 1 | Request to retune the lanes in adjustLanes |
| adjustLanes | output | LANES | Lanes found misaligned |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| trainPass | output | 1 | Sticky pass status |
| trainFail | output | 1 | Sticky fail status |
| phaseErr | output | 3 | Phase that timed out (bit 0 loopback, 1 read, 2 write) |

## Verification
The assertions assume three things about the inputs. First, aligned is pulsed only while adjustReq is high. Second, start is a single-cycle pulse. Third, timeoutCycles is held constant for the whole run, because the configuration-to-write property depends on the budget being non-zero during that run.

The bench's model of the PHY and tuner follows these assumptions. It raises aligned for one cycle only a few cycles after it sees adjustReq. It changes timeoutCycles only between runs, and gives every run a budget larger than a clean phase needs, except in the runs that are meant to time out.

// File: rtl/dsk_train_pkg.sv
package dsk_train_pkg;

  localparam int OPT_W = 8;
  localparam int OPT_TRAIN_BIT = 7;

  typedef enum logic [1:0] {
    EXP_ONES,
    EXP_TOGGLE,
    EXP_PATTERN
  } expMode_e;

  typedef enum logic [1:0] {
    PH_CA,
    PH_RD,
    PH_WR
  } phase_e;

  typedef struct packed {
    logic     clrPhase;
    logic     clrAcc;
    logic     sampEn;
    expMode_e mode;
  } dpStrobe_t;

endpackage

// File: rtl/dsk_train_dp.sv
module dsk_train_dp
  import dsk_train_pkg::*;
#(
  parameter int LANES = 13,
  parameter int WIN = 8,
  parameter int TW = 16,
  parameter logic [LANES-1:0] WR_PATTERN = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             capValid,
  input  logic [LANES-1:0] capData,
  input  logic [TW-1:0]    timeoutCycles,
  output logic             winDone,
  output logic [LANES-1:0] badLanes,
  output logic             expired
);

  localparam int WW = $clog2(WIN + 1);

  logic [WW-1:0]    winCnt;
  logic [TW-1:0]    phaseCnt;
  logic             togRef;
  logic [LANES-1:0] expVec;

  always_comb begin
    case (strb.mode)
      EXP_ONES:    expVec = '1;
      EXP_TOGGLE:  expVec = togRef ? '1 : '0;
      EXP_PATTERN: expVec = WR_PATTERN;
      default:     expVec = '0;
    endcase
  end

  // Mismatch accumulator and the sampling window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      badLanes <= '0;
      winCnt   <= '0;
      togRef   <= 1'b1;
    end else if (strb.clrAcc) begin
      badLanes <= '0;
      winCnt   <= '0;
      togRef   <= 1'b1;
    end else if (strb.sampEn) begin
      winCnt <= winCnt + 1'b1;
      if (capValid) begin
        badLanes <= badLanes | (capData ^ expVec);
        togRef   <= ~togRef;
      end
    end
  end

  assign winDone = strb.sampEn && (winCnt == WW'(WIN - 1));

  // Per-phase cycle budget
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strb.clrPhase) begin
      phaseCnt <= '0;
    end else if (phaseCnt != '1) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign expired = (phaseCnt >= timeoutCycles);

endmodule

// File: rtl/dsk_train_ctrl.sv
module dsk_train_ctrl
  import dsk_train_pkg::*;
#(
  parameter int LANES = 13,
  parameter logic [LANES-1:0] WR_PATTERN = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             aligned,
  input  logic             winDone,
  input  logic             badAny,
  input  logic             expired,
  output dpStrobe_t        strb,
  output logic             cfgMode,
  output logic             regWrEn,
  output logic [OPT_W-1:0] regWrData,
  output logic [1:0]       loopSel,
  output logic             cmdWrite,
  output logic             cmdRead,
  output logic [LANES-1:0] wrData,
  output logic             adjustReq,
  output logic             busy,
  output logic             done,
  output logic             trainPass,
  output logic             trainFail,
  output logic [2:0]       phaseErr
);

  typedef enum logic [4:0] {
    S_IDLE, S_CFG_ON, S_CA_SET, S_CA_SAMP, S_CA_EVAL,
    S_RD_WR, S_RD_RD, S_RD_SAMP, S_RD_EVAL, S_CFG_OFF,
    S_WR_WR, S_WR_RD, S_WR_SAMP, S_WR_EVAL, S_ADJ,
    S_OK, S_FAIL, S_TERM
  } state_e;

  state_e     state, nextState;
  phase_e     phase;
  logic [1:0] group;
  logic       inPhase, caActive, idleLike;

  assign idleLike = (state == S_IDLE) || (state == S_TERM);
  assign inPhase  = !(idleLike || state == S_CFG_ON || state == S_OK || state == S_FAIL);
  assign caActive = (state == S_CA_SET) || (state == S_CA_SAMP) || (state == S_CA_EVAL) ||
                    (state == S_ADJ && phase == PH_CA);

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE, S_TERM: if (start) nextState = S_CFG_ON;
      S_CFG_ON:  nextState = S_CA_SET;
      S_CA_SET:  nextState = S_CA_SAMP;
      S_CA_SAMP: if (winDone) nextState = S_CA_EVAL;
      S_CA_EVAL: nextState = badAny ? S_ADJ : (group == 2'd2 ? S_RD_WR : S_CA_SET);
      S_RD_WR:   nextState = S_RD_RD;
      S_RD_RD:   nextState = S_RD_SAMP;
      S_RD_SAMP: if (winDone) nextState = S_RD_EVAL;
      S_RD_EVAL: nextState = badAny ? S_ADJ : S_CFG_OFF;
      S_CFG_OFF: nextState = S_WR_WR;
      S_WR_WR:   nextState = S_WR_RD;
      S_WR_RD:   nextState = S_WR_SAMP;
      S_WR_SAMP: if (winDone) nextState = S_WR_EVAL;
      S_WR_EVAL: nextState = badAny ? S_ADJ : S_OK;
      S_ADJ: if (aligned) begin
        case (phase)
          PH_CA:   nextState = S_CA_SET;
          PH_RD:   nextState = S_RD_WR;
          default: nextState = S_WR_WR;
        endcase
      end
      S_OK, S_FAIL: nextState = S_TERM;
      default: nextState = S_IDLE;
    endcase
    if (inPhase && expired) nextState = S_FAIL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      phase     <= PH_CA;
      group     <= 2'd0;
      trainPass <= 1'b0;
      trainFail <= 1'b0;
      phaseErr  <= 3'b000;
    end else begin
      state <= nextState;
      if (idleLike && nextState == S_CFG_ON) begin
        trainPass <= 1'b0;
        trainFail <= 1'b0;
        phaseErr  <= 3'b000;
      end
      if (state == S_CFG_ON) begin
        group <= 2'd0;
        phase <= PH_CA;
      end
      if (state == S_CA_EVAL && nextState == S_CA_SET) group <= group + 2'd1;
      if (state == S_CA_EVAL && nextState == S_RD_WR) phase <= PH_RD;
      if (state == S_RD_EVAL && nextState == S_CFG_OFF) phase <= PH_WR;
      if (nextState == S_OK) trainPass <= 1'b1;
      if (nextState == S_FAIL) begin
        trainFail <= 1'b1;
        phaseErr  <= phaseErr | (3'b001 << phase);
      end
    end
  end

  always_comb begin
    strb.clrPhase = (state == S_CFG_ON) ||
                    (state == S_CA_EVAL && nextState == S_RD_WR) ||
                    (state == S_RD_EVAL && nextState == S_CFG_OFF);
    strb.clrAcc   = (state == S_CA_SET) || (state == S_RD_RD) || (state == S_WR_RD);
    strb.sampEn   = (state == S_CA_SAMP) || (state == S_RD_SAMP) || (state == S_WR_SAMP);
    case (phase)
      PH_CA:   strb.mode = EXP_ONES;
      PH_RD:   strb.mode = EXP_TOGGLE;
      default: strb.mode = EXP_PATTERN;
    endcase
  end

  always_comb begin
    regWrData = '0;
    regWrData[OPT_TRAIN_BIT] = (state == S_CFG_ON);
  end

  assign cfgMode   = (state == S_CFG_ON) || (state == S_CFG_OFF);
  assign regWrEn   = cfgMode;
  assign loopSel   = caActive ? group : 2'b11;
  assign cmdWrite  = (state == S_RD_WR) || (state == S_WR_WR);
  assign wrData    = (state == S_RD_WR) ? '1 : ((state == S_WR_WR) ? WR_PATTERN : '0);
  assign cmdRead   = (state == S_RD_RD) || (state == S_WR_RD);
  assign adjustReq = (state == S_ADJ);
  assign busy      = !idleLike;
  assign done      = (state == S_OK) || (state == S_FAIL);

endmodule

// File: rtl/dsk_train_seq.sv
module dsk_train_seq
  import dsk_train_pkg::*;
#(
  parameter int LANES = 13,
  parameter int WIN = 8,
  parameter int TW = 16,
  parameter logic [LANES-1:0] WR_PATTERN = 13'h0A5A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [TW-1:0]    timeoutCycles,
  input  logic             capValid,
  input  logic [LANES-1:0] capData,
  input  logic             aligned,
  output logic             cfgMode,
  output logic             regWrEn,
  output logic [OPT_W-1:0] regWrData,
  output logic [1:0]       loopSel,
  output logic             cmdWrite,
  output logic             cmdRead,
  output logic [LANES-1:0] wrData,
  output logic             adjustReq,
  output logic [LANES-1:0] adjustLanes,
  output logic             busy,
  output logic             done,
  output logic             trainPass,
  output logic             trainFail,
  output logic [2:0]       phaseErr
);

  dpStrobe_t        strb;
  logic             winDone, expired;
  logic [LANES-1:0] badLanes;

  dsk_train_ctrl #(.LANES(LANES), .WR_PATTERN(WR_PATTERN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .aligned(aligned),
    .winDone(winDone), .badAny(|badLanes), .expired(expired), .strb(strb),
    .cfgMode(cfgMode), .regWrEn(regWrEn), .regWrData(regWrData),
    .loopSel(loopSel), .cmdWrite(cmdWrite), .cmdRead(cmdRead),
    .wrData(wrData), .adjustReq(adjustReq), .busy(busy), .done(done),
    .trainPass(trainPass), .trainFail(trainFail), .phaseErr(phaseErr)
  );

  dsk_train_dp #(.LANES(LANES), .WIN(WIN), .TW(TW), .WR_PATTERN(WR_PATTERN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capValid(capValid),
    .capData(capData), .timeoutCycles(timeoutCycles),
    .winDone(winDone), .badLanes(badLanes), .expired(expired)
  );

  assign adjustLanes = adjustReq ? badLanes : '0;

endmodule

// File: rtl/dsk_train_chk.sv
module dsk_train_chk #(
  parameter int LANES = 13,
  parameter int TW = 16,
  parameter logic [LANES-1:0] WR_PATTERN = 13'h0A5A
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [TW-1:0]    timeoutCycles,
  input logic             aligned,
  input logic             cfgMode,
  input logic             regWrEn,
  input logic [7:0]       regWrData,
  input logic [1:0]       loopSel,
  input logic             cmdWrite,
  input logic             cmdRead,
  input logic [LANES-1:0] wrData,
  input logic             adjustReq,
  input logic [LANES-1:0] adjustLanes,
  input logic             busy,
  input logic             done,
  input logic             trainPass,
  input logic             trainFail,
  input logic [2:0]       phaseErr
);

  // R1
  cfg_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode |-> (!cmdWrite && !cmdRead && loopSel == 2'b11));

  // R2
  loop_no_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loopSel != 2'b11) |-> (!cmdWrite && !cmdRead));

  // R3
  adjust_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adjustReq && !aligned) |=> (adjustReq || done));

  // R3
  adjust_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    adjustReq |-> (adjustLanes != '0));

  // R5
  train_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[7] && timeoutCycles != '0) |=> (cmdWrite && wrData == WR_PATTERN));

  // R7
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phaseErr));

  // R7
  fail_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && trainFail) |-> (phaseErr != 3'b000));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (trainPass != trainFail));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !(regWrEn && regWrData[7]));

endmodule

bind dsk_train_seq dsk_train_chk #(.LANES(LANES), .TW(TW), .WR_PATTERN(WR_PATTERN)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .timeoutCycles(timeoutCycles),
  .aligned(aligned), .cfgMode(cfgMode), .regWrEn(regWrEn), .regWrData(regWrData),
  .loopSel(loopSel), .cmdWrite(cmdWrite), .cmdRead(cmdRead), .wrData(wrData),
  .adjustReq(adjustReq), .adjustLanes(adjustLanes), .busy(busy), .done(done),
  .trainPass(trainPass), .trainFail(trainFail), .phaseErr(phaseErr)
);

// File: tb/sim_dsk_train_seq.sv
`timescale 1ns/1ps
module sim_dsk_train_seq;

  localparam int LANES = 13;
  localparam int TW = 16;
  localparam logic [LANES-1:0] PAT = 13'h0A5A;
  localparam logic [LANES-1:0] ONES = '1;

  localparam int K_CFG = 0, K_LOOP = 1, K_WR = 2, K_RD = 3, K_ADJ = 4, K_DONE = 5;

  typedef struct {
    int          kind;
    logic [15:0] val;
  } ev_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [TW-1:0]    timeoutCycles = 16'd2000;
  logic             capValid = 1'b1;
  logic [LANES-1:0] capData = '1;
  logic             aligned = 1'b0;
  logic             cfgMode, regWrEn, cmdWrite, cmdRead, adjustReq, busy, done;
  logic             trainPass, trainFail;
  logic [7:0]       regWrData;
  logic [1:0]       loopSel;
  logic [LANES-1:0] wrData, adjustLanes;
  logic [2:0]       phaseErr;

  int checks = 0;
  int errors = 0;
  ev_t expQ[$];

  // model state
  int               caBad[3];
  logic [LANES-1:0] caMask;
  int               rdBad, wrBad;
  bit               noAlign, trainEn, tog;
  logic [LANES-1:0] lastWr;
  int               alDly;

  // monitor state
  logic [1:0] prevLoop;
  bit         prevAdj, doneSeen;
  int         negCnt, loop0At, doneAt;

  always #2.5 clk = ~clk;

  dsk_train_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .timeoutCycles(timeoutCycles),
    .capValid(capValid), .capData(capData), .aligned(aligned),
    .cfgMode(cfgMode), .regWrEn(regWrEn), .regWrData(regWrData),
    .loopSel(loopSel), .cmdWrite(cmdWrite), .cmdRead(cmdRead), .wrData(wrData),
    .adjustReq(adjustReq), .adjustLanes(adjustLanes), .busy(busy), .done(done),
    .trainPass(trainPass), .trainFail(trainFail), .phaseErr(phaseErr)
  );

  function automatic string tagOf(int kind);
    case (kind)
      K_CFG:   return "R1/R5";
      K_LOOP:  return "R2";
      K_WR:    return "R4/R6";
      K_RD:    return "R4/R6";
      K_ADJ:   return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [15:0] val);
    ev_t e;
    e.kind = kind;
    e.val  = val;
    expQ.push_back(e);
  endtask

  task automatic observe(input int kind, input logic [15:0] val);
    ev_t e;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL %s: actual event %0d/0x%0h expected none", tagOf(kind), kind, val);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.val != val) begin
        errors++;
        $display("FAIL %s: actual event %0d/0x%0h expected %0d/0x%0h",
                 tagOf(e.kind), kind, val, e.kind, e.val);
      end
    end
  endtask

  // driver side: expected order of a run that ends in pass
  task automatic expectPass(input int c0, input int c1, input int c2,
                            input logic [LANES-1:0] m, input int rb, input int wb);
    int cn[3];
    cn[0] = c0; cn[1] = c1; cn[2] = c2;
    push(K_CFG, 16'h0080);
    for (int g = 0; g < 3; g++) begin
      push(K_LOOP, 16'(g));
      for (int i = 0; i < cn[g]; i++) push(K_ADJ, 16'(m));
    end
    push(K_LOOP, 16'd3);
    for (int i = 0; i <= rb; i++) begin
      if (i > 0) push(K_ADJ, 16'(ONES));
      push(K_WR, 16'(ONES));
      push(K_RD, 16'd0);
    end
    push(K_CFG, 16'h0000);
    for (int i = 0; i <= wb; i++) begin
      if (i > 0) push(K_ADJ, 16'(ONES));
      push(K_WR, 16'(PAT));
      push(K_RD, 16'd0);
    end
    push(K_DONE, 16'h0010);
  endtask

  task automatic setModel(input int c0, input int c1, input int c2,
                          input logic [LANES-1:0] m, input int rb, input int wb, input bit na);
    caBad[0] = c0; caBad[1] = c1; caBad[2] = c2;
    caMask = m; rdBad = rb; wrBad = wb; noAlign = na;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    doneSeen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!doneSeen && n < 3000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(doneSeen, "R8 done seen", int'(doneSeen), 1);
    check(!done, "R8 done one cycle", int'(done), 0);
    check(expQ.size() == 0, "R8 all events seen", expQ.size(), 0);
  endtask

  // PHY capture and delay-tuner model
  always @(negedge clk) begin
    if (regWrEn) trainEn = regWrData[7];
    if (cmdWrite) lastWr = wrData;
    if (loopSel != 2'b11) begin
      capData = (caBad[loopSel] > 0) ? ~caMask : ONES;
    end else if (trainEn) begin
      capData = (rdBad > 0) ? '0 : (tog ? ONES : '0);
      tog = ~tog;
      if (cmdRead) tog = 1'b1;
    end else begin
      capData = (wrBad > 0) ? ~lastWr : lastWr;
    end
    if (aligned) begin
      aligned = 1'b0;
    end else if (adjustReq && !noAlign) begin
      if (alDly == 2) begin
        aligned = 1'b1;
        alDly = 0;
        if (loopSel != 2'b11) caBad[loopSel]--;
        else if (trainEn) rdBad--;
        else wrBad--;
      end else begin
        alDly++;
      end
    end else begin
      alDly = 0;
    end
  end

  // monitor: compares produced events against the queue
  always @(negedge clk) begin
    if (!rstN) begin
      prevLoop = 2'b11;
      prevAdj  = 0;
    end else begin
      negCnt++;
      if (regWrEn) observe(K_CFG, {8'h00, regWrData});
      if (loopSel != prevLoop) begin
        observe(K_LOOP, {14'h0, loopSel});
        if (loopSel == 2'd0) loop0At = negCnt;
      end
      prevLoop = loopSel;
      if (cmdWrite) observe(K_WR, 16'(wrData));
      if (cmdRead) observe(K_RD, 16'd0);
      if (adjustReq && !prevAdj) observe(K_ADJ, 16'(adjustLanes));
      prevAdj = adjustReq;
      if (done) begin
        observe(K_DONE, {11'h0, trainPass, trainFail, phaseErr});
        doneAt = negCnt;
        doneSeen = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    setModel(0, 0, 0, '0, 0, 0, 0);
    tog = 1'b1; trainEn = 0; alDly = 0; lastWr = '0;
    negCnt = 0; loop0At = 0; doneAt = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(!done && !busy && !trainPass && !trainFail, "R8 reset status",
          {done, busy, trainPass, trainFail}, 0);
    check(loopSel == 2'b11 && phaseErr == 3'b000, "R8 reset loopSel/phaseErr",
          {loopSel, phaseErr}, 5'b11000);

    // clean run
    setModel(0, 0, 0, '0, 0, 0, 0);
    expectPass(0, 0, 0, '0, 0, 0);
    pulseStart();
    waitDone();
    check(trainPass && !trainFail && phaseErr == 0, "R8 pass status",
          {trainPass, trainFail, phaseErr}, 5'b10000);

    // retries in each phase, restart from terminal, ignored start
    setModel(0, 1, 0, 13'h0011, 1, 2, 0);
    expectPass(0, 1, 0, 13'h0011, 1, 2);
    pulseStart();
    check(!trainPass && busy, "R10 status cleared on restart", {trainPass, busy}, 2'b01);
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !regWrEn, "R9 start ignored while busy", {busy, regWrEn}, 2'b10);
    waitDone();
    check(trainPass && !trainFail, "R3 R4 R6 pass after retries", {trainPass, trainFail}, 2'b10);

    // loopback phase never aligns
    timeoutCycles = 16'd40;
    setModel(99, 0, 0, 13'h0100, 0, 0, 1);
    push(K_CFG, 16'h0080); push(K_LOOP, 16'd0); push(K_ADJ, 16'h0100);
    push(K_LOOP, 16'd3); push(K_DONE, 16'h0009);
    pulseStart();
    waitDone();
    check(trainFail && phaseErr == 3'b001, "R7 loopback timeout flag", {trainFail, phaseErr}, 4'b1001);
    check(doneAt - loop0At == 41, "R7 timeout cycle count", doneAt - loop0At, 41);

    // read phase never aligns
    timeoutCycles = 16'd60;
    setModel(0, 0, 0, '0, 99, 0, 1);
    push(K_CFG, 16'h0080);
    for (int g = 0; g < 4; g++) push(K_LOOP, 16'(g));
    push(K_WR, 16'(ONES)); push(K_RD, 16'd0); push(K_ADJ, 16'(ONES));
    push(K_DONE, 16'h000A);
    pulseStart();
    waitDone();
    check(trainFail && phaseErr == 3'b010, "R7 read timeout flag", {trainFail, phaseErr}, 4'b1010);

    // write phase never aligns
    setModel(0, 0, 0, '0, 0, 99, 1);
    push(K_CFG, 16'h0080);
    for (int g = 0; g < 4; g++) push(K_LOOP, 16'(g));
    push(K_WR, 16'(ONES)); push(K_RD, 16'd0); push(K_CFG, 16'h0000);
    push(K_WR, 16'(PAT)); push(K_RD, 16'd0); push(K_ADJ, 16'(ONES));
    push(K_DONE, 16'h000C);
    pulseStart();
    waitDone();
    check(trainFail && phaseErr == 3'b100, "R7 write timeout flag", {trainFail, phaseErr}, 4'b1100);
    repeat (5) @(negedge clk);
    check(!busy && trainFail && !trainPass, "R8 terminal status held",
          {busy, trainFail, trainPass}, 3'b010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule